// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small fully associative cache of page translations. Each entry maps one virtual page number to a physical page number plus a few attribute bits. Every guest entry carries the identifier of the virtual machine that owns it and the address-space identifier of the owning application. Several guests and the applications inside them can therefore keep entries in the same cache at once, and nothing has to be flushed when the running context changes. Entries created for the hypervisor or the monitor carry no machine identifier.

A lookup presents a virtual page, the current address space, the current machine identifier and the current privilege level. One cycle later the block returns a hit flag, the physical page and the attributes. A fill port writes a new mapping. Three invalidate commands remove entries: all of them, those of one machine, or those of one address space within one machine. The machine identifier can be switched between 8 and 16 bits at run time. A parameter can remove the wide mode altogether.

Top module: `tagged_xlate_cache`

## Requirements
- R1: `hit_o` is registered. It reports the lookup presented in the previous cycle. It is 0 in a cycle that follows a cycle with `lk_valid` low, and it is 0 after reset.
- R2: A guest lookup (`lk_priv` 0 = user or 1 = kernel) hits a guest entry only when the page number, the effective machine identifier and the address space all match. On a hit the entry's `ppn_o` and `attr_o` are returned.
- R3: A guest entry with a matching address space and page but a different machine identifier never hits.
- R4: A global guest entry (`fill_global` = 1) matches any address space. It still needs its machine identifier to match.
- R5: A lookup with `lk_priv` 2 (hypervisor) or 3 (monitor) hits only host entries (`fill_host` = 1), on the page number alone. Guest lookups never hit host entries.
- R6: When `vmid_wide` = 0 (or `VMID16_EN` = 0), bits 15:8 of every machine identifier are ignored. This applies to lookup, fill and invalidate; filled entries store them as zero.
- R7: When `vmid_wide` = 1 and `VMID16_EN` = 1, all 16 identifier bits take part in the compare.
- R8: A fill that matches no existing entry writes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at `ENTRIES`, only on such a fill.
- R9: A fill whose class, page, stored identifier, address space and global flag all equal those of a valid entry overwrites that entry in place. The pointer does not move.
- R10: `inv_op` = 2 removes every guest entry whose machine identifier matches `inv_vmid`, in one cycle. Host entries and the entries of other machines stay.
- R11: `inv_op` = 3 removes non-global guest entries that match both `inv_vmid` and `inv_asid`. Global entries stay.
- R12: `inv_op` = 1 removes every entry (`inv_op` = 0 is no operation).
- R13: A lookup in the same cycle as a fill or an invalidate sees the contents from before that cycle. When several entries match, the lowest index is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vmid_wide | input | 1 | 1 selects 16-bit machine identifiers, 0 selects 8-bit |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address space |
| lk_vmid | input | 16 | Current machine identifier |
| lk_priv | input | 2 | Privilege: 0 user, 1 kernel, 2 hypervisor, 3 monitor |
| fill_valid | input | 1 | Write a mapping |
| fill_host | input | 1 | The mapping belongs to hypervisor or monitor (untagged) |
| fill_global | input | 1 | Guest mapping shared by all address spaces of its machine |
| fill_vpn | input | VPN_W | Virtual page of the mapping |
| fill_asid | input | ASID_W | Address space of the mapping |
| fill_vmid | input | 16 | Machine identifier of the mapping |
| fill_ppn | input | PPN_W | Physical page of the mapping |
| fill_attr | input | ATTR_W | Attributes of the mapping |
| inv_op | input | 2 | 0 none, 1 all, 2 by machine, 3 by machine and address space |
| inv_vmid | input | 16 | Machine identifier for invalidation |
| inv_asid | input | ASID_W | Address space for invalidation |
| hit_o | output | 1 | Registered hit |
| ppn_o | output | PPN_W | Registered physical page |
| attr_o | output | ATTR_W | Registered attributes |

## Verification
The bench builds the block with its defaults: eight entries and the wide identifier mode available. With these values the bench can switch `vmid_wide` at run time. It can show that two identifiers with equal low bytes collide in narrow mode and stay apart in wide mode. It can also show that entries filled narrow stay reachable afterwards. Eight slots are few enough that a ninth distinct fill wraps the replacement pointer. Directed sequences cover this, and so does a long random phase over small value ranges, where duplicate fills, global/non-global overlaps and invalidates that coincide with lookups happen often.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VMID_W = 16;

  localparam logic [1:0] INV_NONE  = 2'd0;
  localparam logic [1:0] INV_ALL   = 2'd1;
  localparam logic [1:0] INV_VM    = 2'd2;
  localparam logic [1:0] INV_VM_AS = 2'd3;

  // Identifier as seen by compares and storage under the active width mode
  function automatic logic [VMID_W-1:0] vmid_eff(input logic [VMID_W-1:0] v, input logic wide);
    return wide ? v : {8'h00, v[7:0]};
  endfunction

  // Privilege levels 2 and 3 run without the second translation stage
  function automatic logic priv_is_host(input logic [1:0] p);
    return p[1];
  endfunction
endpackage

// File: rtl/xc_rr_ptr.sv
module xc_rr_ptr #(
  parameter int N = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (step)    ptr <= (ptr == PW'(N-1)) ? '0 : ptr + PW'(1);
  end

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr == (($past(ptr) == PW'(N-1)) ? '0 : $past(ptr) + PW'(1)));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));
endmodule

// File: rtl/xc_entry_cmp.sv
module xc_entry_cmp import xc_pkg::*; #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 16
) (
  input  logic              e_valid,
  input  logic              e_host,
  input  logic              e_global,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic              q_host,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VMID_W-1:0] q_vmid,
  input  logic              f_host,
  input  logic              f_global,
  input  logic [VPN_W-1:0]  f_vpn,
  input  logic [ASID_W-1:0] f_asid,
  input  logic [VMID_W-1:0] f_vmid,
  input  logic [1:0]        i_op,
  input  logic [VMID_W-1:0] i_vmid,
  input  logic [ASID_W-1:0] i_asid,
  output logic              lk_match,
  output logic              fill_same,
  output logic              inv_drop
);
  logic guest_vm_eq;
  assign guest_vm_eq = !e_host && (e_vmid == q_vmid);

  assign lk_match = e_valid && (e_vpn == q_vpn) &&
                    (q_host ? e_host : (guest_vm_eq && (e_global || e_asid == q_asid)));

  assign fill_same = e_valid && (e_host == f_host) && (e_vpn == f_vpn) &&
                     (e_vmid == f_vmid) && (e_asid == f_asid) && (e_global == f_global);

  always_comb begin
    unique case (i_op)
      INV_ALL:   inv_drop = e_valid;
      INV_VM:    inv_drop = e_valid && !e_host && (e_vmid == i_vmid);
      INV_VM_AS: inv_drop = e_valid && !e_host && !e_global &&
                            (e_vmid == i_vmid) && (e_asid == i_asid);
      default:   inv_drop = 1'b0;
    endcase
  end
endmodule

// File: rtl/tagged_xlate_cache.sv
module tagged_xlate_cache import xc_pkg::*; #(
  parameter int ENTRIES   = 8,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 24,
  parameter int ASID_W    = 16,
  parameter int ATTR_W    = 4,
  parameter bit VMID16_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vmid_wide,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [15:0]       lk_vmid,
  input  logic [1:0]        lk_priv,
  input  logic              fill_valid,
  input  logic              fill_host,
  input  logic              fill_global,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [15:0]       fill_vmid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [1:0]        inv_op,
  input  logic [15:0]       inv_vmid,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic wide_eff;
  assign wide_eff = VMID16_EN ? vmid_wide : 1'b0;

  // Entry storage
  logic [ENTRIES-1:0] valid_q, host_q, glob_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VMID_W-1:0]  vmid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];

  // Normalised request fields
  logic              q_host, f_glob_n;
  logic [VMID_W-1:0] q_vmid, f_vmid_n, i_vmid;
  logic [ASID_W-1:0] f_asid_n;
  assign q_host   = priv_is_host(lk_priv);
  assign q_vmid   = vmid_eff(lk_vmid, wide_eff);
  assign i_vmid   = vmid_eff(inv_vmid, wide_eff);
  assign f_vmid_n = fill_host ? '0 : vmid_eff(fill_vmid, wide_eff);
  assign f_asid_n = fill_host ? '0 : fill_asid;
  assign f_glob_n = fill_host ? 1'b0 : fill_global;

  // Named per-entry events
  logic [ENTRIES-1:0] lk_match, fill_same, inv_drop;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xc_entry_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cmp (
      .e_valid(valid_q[g]), .e_host(host_q[g]), .e_global(glob_q[g]),
      .e_vpn(vpn_q[g]), .e_asid(asid_q[g]), .e_vmid(vmid_q[g]),
      .q_host(q_host), .q_vpn(lk_vpn), .q_asid(lk_asid), .q_vmid(q_vmid),
      .f_host(fill_host), .f_global(f_glob_n), .f_vpn(fill_vpn),
      .f_asid(f_asid_n), .f_vmid(f_vmid_n),
      .i_op(inv_op), .i_vmid(i_vmid), .i_asid(inv_asid),
      .lk_match(lk_match[g]), .fill_same(fill_same[g]), .inv_drop(inv_drop[g])
    );
  end

  // Lowest-index selection for lookups and in-place fills
  logic [PW-1:0] lk_idx, dup_idx, wr_idx, rr_ptr;
  always_comb begin
    lk_idx  = '0;
    dup_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (lk_match[i])  lk_idx  = PW'(i);
      if (fill_same[i]) dup_idx = PW'(i);
    end
  end

  logic alloc_evt, dup_evt, lk_hit_now;
  assign dup_evt    = fill_valid && (|fill_same);
  assign alloc_evt  = fill_valid && !(|fill_same);
  assign wr_idx     = dup_evt ? dup_idx : rr_ptr;
  assign lk_hit_now = lk_valid && (|lk_match);

  xc_rr_ptr #(.N(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .step(alloc_evt), .ptr(rr_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_valid && wr_idx == PW'(i)) valid_q[i] <= 1'b1;
        else if (inv_drop[i])               valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_valid && wr_idx == PW'(i)) begin
        host_q[i] <= fill_host;
        glob_q[i] <= f_glob_n;
        vpn_q[i]  <= fill_vpn;
        asid_q[i] <= f_asid_n;
        vmid_q[i] <= f_vmid_n;
        ppn_q[i]  <= fill_ppn;
        attr_q[i] <= fill_attr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o  <= 1'b0;
      ppn_o  <= '0;
      attr_o <= '0;
    end else begin
      hit_o  <= lk_hit_now;
      ppn_o  <= lk_hit_now ? ppn_q[lk_idx]  : '0;
      attr_o <= lk_hit_now ? attr_q[lk_idx] : '0;
    end
  end

  // R1
  no_lookup_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !hit_o);
  // R12
  inv_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_op == INV_ALL && !fill_valid) |=> valid_q == '0);
  // R9
  dup_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_evt && inv_op == INV_NONE) |=> $countones(valid_q) == $countones($past(valid_q)));
  // R6
  narrow_fill_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !wide_eff) |=> vmid_q[$past(wr_idx)][15:8] == 8'h00);
  // R5
  host_hit_only_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && q_host) |-> ((lk_match & ~host_q) == '0));
endmodule

// File: tb/tagged_xlate_cache_test.sv
module tagged_xlate_cache_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int N = 8, VPN_W = 20, PPN_W = 24, ASID_W = 16, ATTR_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, vmid_wide = 1'b1;
  logic lk_valid = 1'b0, fill_valid = 1'b0, fill_host = 1'b0, fill_global = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0, fill_asid = '0, inv_asid = '0;
  logic [15:0] lk_vmid = '0, fill_vmid = '0, inv_vmid = '0;
  logic [1:0] lk_priv = '0, inv_op = '0;
  logic [PPN_W-1:0] fill_ppn = '0, ppn_o;
  logic [ATTR_W-1:0] fill_attr = '0, attr_o;
  logic hit_o;

  tagged_xlate_cache uut (
    .clk(clk), .rst_n(rst_n), .vmid_wide(vmid_wide),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_vmid(lk_vmid), .lk_priv(lk_priv),
    .fill_valid(fill_valid), .fill_host(fill_host), .fill_global(fill_global),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_vmid(fill_vmid),
    .fill_ppn(fill_ppn), .fill_attr(fill_attr),
    .inv_op(inv_op), .inv_vmid(inv_vmid), .inv_asid(inv_asid),
    .hit_o(hit_o), .ppn_o(ppn_o), .attr_o(attr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural model
  bit               m_v[N], m_h[N], m_g[N];
  logic [VPN_W-1:0] m_vpn[N];
  logic [ASID_W-1:0] m_asid[N];
  logic [15:0]      m_vmid[N];
  logic [PPN_W-1:0] m_ppn[N];
  logic [ATTR_W-1:0] m_attr[N];
  int               m_rr = 0;

  function automatic logic [15:0] narrow_or_wide(logic [15:0] v, logic w);
    logic [15:0] r;
    r = v;
    if (!w) r[15:8] = 8'h00;
    return r;
  endfunction

  task automatic cyc(string tag);
    bit e_hit; logic [PPN_W-1:0] e_ppn; logic [ATTR_W-1:0] e_attr;
    bit kill[N]; int dup; logic [15:0] fv, iv, qv; logic [ASID_W-1:0] fa; bit fg;
    e_hit = 0; e_ppn = '0; e_attr = '0;
    qv = narrow_or_wide(lk_vmid, vmid_wide);
    if (lk_valid) begin
      for (int i = 0; i < N; i++) begin
        bit ok;
        ok = m_v[i] && m_vpn[i] == lk_vpn;
        if (lk_priv >= 2) ok = ok && m_h[i];
        else ok = ok && !m_h[i] && m_vmid[i] == qv && (m_g[i] || m_asid[i] == lk_asid);
        if (ok && !e_hit) begin e_hit = 1; e_ppn = m_ppn[i]; e_attr = m_attr[i]; end
      end
    end
    @(posedge clk);
    iv = narrow_or_wide(inv_vmid, vmid_wide);
    for (int i = 0; i < N; i++) begin
      kill[i] = 0;
      if (inv_op == 2'd1) kill[i] = 1;
      if (inv_op == 2'd2) kill[i] = !m_h[i] && m_vmid[i] == iv;
      if (inv_op == 2'd3) kill[i] = !m_h[i] && !m_g[i] && m_vmid[i] == iv && m_asid[i] == inv_asid;
    end
    dup = -1;
    if (fill_valid) begin
      fv = fill_host ? 16'h0 : narrow_or_wide(fill_vmid, vmid_wide);
      fa = fill_host ? '0 : fill_asid;
      fg = fill_host ? 1'b0 : fill_global;
      for (int i = N-1; i >= 0; i--)
        if (m_v[i] && m_h[i] == fill_host && m_vpn[i] == fill_vpn && m_vmid[i] == fv &&
            m_asid[i] == fa && m_g[i] == fg) dup = i;
    end
    for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
    if (fill_valid) begin
      int w;
      w = (dup >= 0) ? dup : m_rr;
      if (dup < 0) m_rr = (m_rr + 1) % N;
      m_v[w] = 1; m_h[w] = fill_host; m_g[w] = fg; m_vpn[w] = fill_vpn;
      m_asid[w] = fa; m_vmid[w] = fv; m_ppn[w] = fill_ppn; m_attr[w] = fill_attr;
    end
    @(negedge clk);
    checks++;
    if (hit_o !== e_hit || (e_hit && (ppn_o !== e_ppn || attr_o !== e_attr))) begin
      failures++;
      $display("FAIL %s: hit=%0b ppn=%h attr=%h expected hit=%0b ppn=%h attr=%h",
               tag, hit_o, ppn_o, attr_o, e_hit, e_ppn, e_attr);
    end
  endtask

  task automatic expect_lit(string tag, bit eh, logic [PPN_W-1:0] ep);
    checks++;
    if (hit_o !== eh || (eh && ppn_o !== ep)) begin
      failures++;
      $display("FAIL %s: hit=%0b ppn=%h expected hit=%0b ppn=%h", tag, hit_o, ppn_o, eh, ep);
    end
  endtask

  task automatic quiet();
    lk_valid = 0; fill_valid = 0; inv_op = 2'd0;
  endtask

  task automatic fill(string tag, bit h, bit g, int vpn, int asid, int vm, int ppn);
    fill_valid = 1; fill_host = h; fill_global = g; fill_vpn = VPN_W'(vpn);
    fill_asid = ASID_W'(asid); fill_vmid = 16'(vm); fill_ppn = PPN_W'(ppn);
    fill_attr = ATTR_W'(ppn);
    cyc(tag); quiet();
  endtask

  task automatic look(string tag, int priv, int vpn, int asid, int vm);
    lk_valid = 1; lk_priv = 2'(priv); lk_vpn = VPN_W'(vpn);
    lk_asid = ASID_W'(asid); lk_vmid = 16'(vm);
    cyc(tag); quiet();
  endtask

  task automatic inv(string tag, int op, int vm, int asid);
    inv_op = 2'(op); inv_vmid = 16'(vm); inv_asid = ASID_W'(asid);
    cyc(tag); quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    expect_lit("R1 reset", 0, '0);
    rst_n = 1;
    @(negedge clk);
    cyc("R1 idle");
    expect_lit("R1 idle literal", 0, '0);

    // R2 / R3
    fill("R2 fill", 0, 0, 'h100, 5, 3, 'hA1);
    look("R2 hit", 0, 'h100, 5, 3);  expect_lit("R2 literal", 1, 'hA1);
    look("R3 other vm", 1, 'h100, 5, 4); expect_lit("R3 literal", 0, '0);
    look("R2 other asid", 0, 'h100, 6, 3); expect_lit("R2 asid literal", 0, '0);
    // R4
    fill("R4 fill global", 0, 1, 'h200, 1, 3, 'hB2);
    look("R4 any asid", 0, 'h200, 9, 3); expect_lit("R4 literal", 1, 'hB2);
    look("R4 vm needed", 0, 'h200, 9, 7); expect_lit("R4 vm literal", 0, '0);
    // R5
    fill("R5 fill host", 1, 0, 'h300, 2, 9, 'hC3);
    look("R5 hyp", 2, 'h300, 0, 'h55); expect_lit("R5 hyp literal", 1, 'hC3);
    look("R5 mon", 3, 'h300, 7, 1);    expect_lit("R5 mon literal", 1, 'hC3);
    look("R5 guest miss", 1, 'h300, 0, 0); expect_lit("R5 guest literal", 0, '0);
    look("R5 hyp no guest", 2, 'h100, 5, 3); expect_lit("R5 hyp guest literal", 0, '0);
    // R6 / R7
    vmid_wide = 0;
    fill("R6 fill narrow", 0, 0, 'h400, 1, 'h1203, 'hD4);
    look("R6 upper ignored", 0, 'h400, 1, 'h7703); expect_lit("R6 literal", 1, 'hD4);
    vmid_wide = 1;
    look("R7 stored narrow reachable", 0, 'h400, 1, 'h0003); expect_lit("R7 literal a", 1, 'hD4);
    look("R7 wide distinct", 0, 'h400, 1, 'h1203); expect_lit("R7 literal b", 0, '0);
    fill("R7 fill wide", 0, 0, 'h500, 1, 'h1203, 'hE5);
    look("R7 wide miss", 0, 'h500, 1, 'h0203); expect_lit("R7 literal c", 0, '0);
    look("R7 wide hit", 0, 'h500, 1, 'h1203); expect_lit("R7 literal d", 1, 'hE5);
    // R9 overwrite in place
    fill("R9 refill", 0, 0, 'h100, 5, 3, 'hF9);
    look("R9 new ppn", 0, 'h100, 5, 3); expect_lit("R9 literal", 1, 'hF9);
    // R13 lookup concurrent with invalidate sees old state
    lk_valid = 1; lk_priv = 0; lk_vpn = 'h100; lk_asid = 5; lk_vmid = 3;
    inv_op = 2'd2; inv_vmid = 3;
    cyc("R13 lookup with inv"); quiet(); expect_lit("R13 literal", 1, 'hF9);
    // R10
    look("R10 vm3 gone", 0, 'h200, 0, 3); expect_lit("R10 literal a", 0, '0);
    look("R10 host kept", 2, 'h300, 0, 0); expect_lit("R10 literal b", 1, 'hC3);
    look("R10 other vm kept", 0, 'h500, 1, 'h1203); expect_lit("R10 literal c", 1, 'hE5);
    // R11
    fill("R11 g", 0, 1, 'h600, 4, 8, 'h16);
    fill("R11 ng", 0, 0, 'h700, 4, 8, 'h17);
    inv("R11 inv", 3, 8, 4);
    look("R11 global kept", 0, 'h600, 4, 8); expect_lit("R11 literal a", 1, 'h16);
    look("R11 nonglobal gone", 0, 'h700, 4, 8); expect_lit("R11 literal b", 0, '0);
    // R12
    inv("R12 inv all", 1, 0, 0);
    look("R12 host gone", 2, 'h300, 0, 0); expect_lit("R12 literal", 0, '0);
    // R8 round robin: nine distinct fills evict the oldest of the nine
    for (int k = 0; k < 9; k++) fill("R8 fill", 0, 0, 'h800 + k, 1, 1, 'h80 + k);
    look("R8 oldest evicted", 0, 'h800, 1, 1); expect_lit("R8 literal a", 0, '0);
    look("R8 newest present", 0, 'h808, 1, 1); expect_lit("R8 literal b", 1, 'h88);

    // Random phase compared every cycle (all requirements, R13 overlaps)
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] vms[3];
      vms[0] = 16'h0003; vms[1] = 16'h0103; vms[2] = 16'h0004;
      if ($urandom_range(0, 15) == 0) vmid_wide = 1'($urandom_range(0, 1));
      lk_valid = 1'($urandom_range(0, 1)); lk_priv = 2'($urandom_range(0, 3));
      lk_vpn = VPN_W'($urandom_range(0, 3)); lk_asid = ASID_W'($urandom_range(0, 2));
      lk_vmid = vms[$urandom_range(0, 2)];
      fill_valid = ($urandom_range(0, 2) == 0); fill_host = ($urandom_range(0, 4) == 0);
      fill_global = ($urandom_range(0, 3) == 0); fill_vpn = VPN_W'($urandom_range(0, 3));
      fill_asid = ASID_W'($urandom_range(0, 2)); fill_vmid = vms[$urandom_range(0, 2)];
      fill_ppn = PPN_W'($urandom); fill_attr = ATTR_W'($urandom);
      inv_op = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      inv_vmid = vms[$urandom_range(0, 2)]; inv_asid = ASID_W'($urandom_range(0, 2));
      cyc("R13 random");
    end
    quiet();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule